// File: doc/BRIEF.md
# External Inquire Snoop Responder

This block answers an inquire (snoop) cycle that arrives from outside the core against a split cache. One side is a data cache whose lines carry four coherence states (invalid, shared, exclusive, modified). The other side is an instruction cache whose lines are only valid or invalid. A snoop request carries a line address and an invalidate qualifier. The block presents that address to both tag arrays and reads back hit and state. It then works out the new line state for each cache and writes it back through a per-cache update port.

When the data-cache line is modified, the block drives a hit-modified indication to the bus side. It then requests a writeback of the line and holds the state update until the writeback completes. The snoop is acknowledged only after any state update has been written. The tag arrays, the data arrays and the bus unit lie outside the block and appear as plain ports.

A line counts as hit in the data cache when the tag matches and its state is not invalid. A line counts as hit in the instruction cache when the tag matches and the valid bit is set. A snoop that hits neither cache is a miss.

Top module: `snoop_responder`

## Requirements
- R1: With the invalidate qualifier low, an instruction-cache hit produces no instruction-cache update, so the line keeps its state.
- R2: With the invalidate qualifier high, an instruction-cache hit writes the line invalid (ic_upd_en high with ic_upd_valid low) in the update cycle.
- R3: With the invalidate qualifier low, a data-cache hit on an exclusive or modified line writes the shared state. A hit on a shared line causes no write, and an invalid line is never written.
- R4: hitm is high from the lookup cycle through the cycle in which wb_done is seen, and only for a hit on a modified data-cache line. It stays low for shared and exclusive hits.
- R5: A modified data-cache line is written back (wb_req until wb_done) before its state update is issued. The update follows in the cycle after wb_done.
- R6: With the invalidate qualifier high, a data-cache hit writes the invalid state.
- R7: snp_ack is a one-cycle pulse in the cycle after the update cycle for any hit.
- R8: A snoop that misses both caches is acknowledged in the cycle after the lookup cycle, with no update on either cache.
- R9: wb_req stays high every cycle until wb_done is seen, and wb_addr and tag_addr carry the snooped address.
- R10: Data-cache states are encoded I=2'b00, S=2'b01, E=2'b10, M=2'b11 on dc_lkp_state and dc_upd_state.
- R11: After reset, snp_ack, hitm, wb_req, dc_upd_en and ic_upd_en are low.
- R12: A snoop request raised while a snoop is in progress is ignored. Exactly one acknowledge is produced per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_req | input | 1 | Snoop request, accepted when idle |
| snp_addr | input | AW | Snooped line address |
| snp_inval | input | 1 | Invalidate qualifier |
| snp_ack | output | 1 | Snoop complete pulse |
| hitm | output | 1 | Hit on a modified data line |
| tag_addr | output | AW | Address presented to both tag arrays |
| dc_lkp_hit | input | 1 | Data-cache tag match |
| dc_lkp_state | input | 2 | Data-cache line state |
| ic_lkp_hit | input | 1 | Instruction-cache tag match |
| ic_lkp_valid | input | 1 | Instruction-cache valid bit |
| dc_upd_en | output | 1 | Data-cache state write strobe |
| dc_upd_state | output | 2 | Data-cache state to write |
| ic_upd_en | output | 1 | Instruction-cache state write strobe |
| ic_upd_valid | output | 1 | Instruction-cache valid bit to write |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | AW | Writeback line address |
| wb_done | input | 1 | Writeback completed |

## Verification
The bench sweeps every combination of tag match, line state, valid bit and invalidate qualifier, with several writeback latencies. For each case it predicts the hit-modified window, the update values and their cycle, and the acknowledge cycle. One corner case is a modified hit: a design that updates before the writeback finishes would downgrade a line whose data is still dirty. Another is a hit on a shared line without invalidate: a design that writes it anyway, or that raises hitm on exclusive hits, gives a wrong bus response. The bench also checks the exact acknowledge cycle for misses and for invalid-state tag matches. It also issues a second request in mid-snoop, which a careless design would accept and acknowledge twice.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    DC_I = 2'b00,
    DC_S = 2'b01,
    DC_E = 2'b10,
    DC_M = 2'b11
  } dc_state_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LKP  = 3'd1,
    ST_WB   = 3'd2,
    ST_UPD  = 3'd3,
    ST_ACK  = 3'd4
  } snp_fsm_e;

  // next data-cache state for a snooped line
  function automatic dc_state_e dc_next(input dc_state_e cur, input logic inv);
    if (cur == DC_I) return DC_I;
    return inv ? DC_I : DC_S;
  endfunction

  // next instruction-cache valid bit
  function automatic logic ic_next(input logic valid, input logic inv);
    return valid & ~inv;
  endfunction

  function automatic logic dc_needs_wb(input logic hit, input dc_state_e cur);
    return hit && (cur == DC_M);
  endfunction

endpackage

// File: rtl/snp_state_calc.sv
module snp_state_calc
  import snp_pkg::*;
(
  input  logic      inv,
  input  logic      dc_hit,
  input  dc_state_e dc_cur,
  input  logic      ic_hit,
  input  logic      ic_valid,
  output dc_state_e dc_nxt,
  output logic      dc_chg,
  output logic      ic_nxt,
  output logic      ic_chg,
  output logic      need_wb,
  output logic      hit_any
);
  logic dc_live, ic_live;

  always_comb begin
    dc_live = dc_hit && (dc_cur != DC_I);
    ic_live = ic_hit && ic_valid;
    dc_nxt  = dc_next(dc_cur, inv);
    ic_nxt  = ic_next(ic_valid, inv);
    dc_chg  = dc_live && (dc_nxt != dc_cur);
    ic_chg  = ic_live && (ic_nxt != ic_valid);
    need_wb = dc_needs_wb(dc_hit, dc_cur);
    hit_any = dc_live || ic_live;
  end
endmodule

// File: rtl/snp_ctrl.sv
module snp_ctrl
  import snp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic need_wb,
  input  logic hit_any,
  input  logic wb_done,
  output logic in_lkp,
  output logic in_wb,
  output logic in_upd,
  output logic in_ack
);
  snp_fsm_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req) st_d = ST_LKP;
      ST_LKP:  st_d = need_wb ? ST_WB : (hit_any ? ST_UPD : ST_ACK);
      ST_WB:   if (wb_done) st_d = ST_UPD;
      ST_UPD:  st_d = ST_ACK;
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign in_lkp = (st_q == ST_LKP);
  assign in_wb  = (st_q == ST_WB);
  assign in_upd = (st_q == ST_UPD);
  assign in_ack = (st_q == ST_ACK);

  // R9: writeback request held until done
  p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wb && !wb_done) |=> in_wb);
  // R12: only one acknowledge per accepted request
  p_ack_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> !in_ack);
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_req,
  input  logic [AW-1:0] snp_addr,
  input  logic          snp_inval,
  output logic          snp_ack,
  output logic          hitm,
  output logic [AW-1:0] tag_addr,
  input  logic          dc_lkp_hit,
  input  logic [1:0]    dc_lkp_state,
  input  logic          ic_lkp_hit,
  input  logic          ic_lkp_valid,
  output logic          dc_upd_en,
  output logic [1:0]    dc_upd_state,
  output logic          ic_upd_en,
  output logic          ic_upd_valid,
  output logic          wb_req,
  output logic [AW-1:0] wb_addr,
  input  logic          wb_done
);
  // named internal events
  logic in_lkp, in_wb, in_upd, in_ack;
  logic accept;
  logic need_wb, hit_any, dc_chg, ic_chg, ic_nxt;
  dc_state_e dc_nxt, dc_cur;

  logic [AW-1:0] addr_q;
  logic          inv_q;
  dc_state_e     dc_nxt_q, dc_cur_q;
  logic          dc_chg_q, ic_chg_q, ic_nxt_q, hit_q;

  assign dc_cur = dc_state_e'(dc_lkp_state);
  assign accept = snp_req && !in_lkp && !in_wb && !in_upd && !in_ack;

  snp_state_calc u_calc (
    .inv      (inv_q),
    .dc_hit   (dc_lkp_hit),
    .dc_cur   (dc_cur),
    .ic_hit   (ic_lkp_hit),
    .ic_valid (ic_lkp_valid),
    .dc_nxt   (dc_nxt),
    .dc_chg   (dc_chg),
    .ic_nxt   (ic_nxt),
    .ic_chg   (ic_chg),
    .need_wb  (need_wb),
    .hit_any  (hit_any)
  );

  snp_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (snp_req),
    .need_wb (need_wb),
    .hit_any (hit_any),
    .wb_done (wb_done),
    .in_lkp  (in_lkp),
    .in_wb   (in_wb),
    .in_upd  (in_upd),
    .in_ack  (in_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      inv_q    <= 1'b0;
      dc_nxt_q <= DC_I;
      dc_cur_q <= DC_I;
      dc_chg_q <= 1'b0;
      ic_chg_q <= 1'b0;
      ic_nxt_q <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= snp_addr;
        inv_q  <= snp_inval;
      end
      if (in_lkp) begin
        dc_nxt_q <= dc_nxt;
        dc_cur_q <= dc_cur;
        dc_chg_q <= dc_chg;
        ic_chg_q <= ic_chg;
        ic_nxt_q <= ic_nxt;
        hit_q    <= hit_any;
      end
    end
  end

  assign tag_addr     = addr_q;
  assign wb_addr      = addr_q;
  assign wb_req       = in_wb;
  assign hitm         = (in_lkp && need_wb) || in_wb;
  assign dc_upd_en    = in_upd && dc_chg_q;
  assign dc_upd_state = dc_nxt_q;
  assign ic_upd_en    = in_upd && ic_chg_q;
  assign ic_upd_valid = ic_nxt_q;
  assign snp_ack      = in_ack;

  // R1: no instruction-cache write without invalidate
  p_ic_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ic_upd_en |-> inv_q);
  // R2: instruction-cache writes only ever invalidate
  p_ic_inval_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ic_upd_en |-> !ic_upd_valid);
  // R3: data writes without invalidate land in shared
  p_dc_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_upd_en && !inv_q) |-> (dc_upd_state == 2'b01));
  // R4: hitm only for a modified line
  p_hitm_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hitm |-> ((in_lkp && dc_lkp_hit && dc_lkp_state == 2'b11) ||
              (in_wb && dc_cur_q == DC_M)));
  // R5: modified line updated only right after writeback done
  p_wb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_upd_en && dc_cur_q == DC_M) |-> $past(wb_done && wb_req));
  // R6: invalidate writes invalid
  p_dc_inval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_upd_en && inv_q) |-> (dc_upd_state == 2'b00));
  // R7: ack for a hit follows the update cycle
  p_ack_after_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_ack && hit_q) |-> $past(in_upd));
  // R8: a miss is acknowledged right after lookup
  p_miss_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lkp && !hit_any) |=> (snp_ack && !dc_upd_en && !ic_upd_en));
endmodule

// File: tb/sim_snoop_responder.sv
module sim_snoop_responder;
  localparam int CLK_NS = 10;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic snp_req = 0, snp_inval = 0, dc_lkp_hit = 0, ic_lkp_hit = 0, ic_lkp_valid = 0, wb_done = 0;
  logic [AW-1:0] snp_addr = '0;
  logic [1:0] dc_lkp_state = 2'b00;
  logic snp_ack, hitm, dc_upd_en, ic_upd_en, ic_upd_valid, wb_req;
  logic [1:0] dc_upd_state;
  logic [AW-1:0] tag_addr, wb_addr;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  snoop_responder #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .snp_req(snp_req), .snp_addr(snp_addr),
    .snp_inval(snp_inval), .snp_ack(snp_ack), .hitm(hitm), .tag_addr(tag_addr),
    .dc_lkp_hit(dc_lkp_hit), .dc_lkp_state(dc_lkp_state), .ic_lkp_hit(ic_lkp_hit),
    .ic_lkp_valid(ic_lkp_valid), .dc_upd_en(dc_upd_en), .dc_upd_state(dc_upd_state),
    .ic_upd_en(ic_upd_en), .ic_upd_valid(ic_upd_valid), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_done(wb_done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic run_case(input int inv, input int dch, input int dcs,
                          input int ich, input int icv, input int d, input int seq);
    int hitm_n, wb_n, ack_n, ack_at, dcu_n, dcu_at, dcu_val, icu_n, icu_at, icu_val;
    int addr_ok, hitm_last;
    int vdc, vic, hit, m, exp_ack, exp_dcu, exp_icu;
    logic [AW-1:0] a;
    a = AW'(16'h1357 ^ (seq * 16'h0101));
    hitm_n = 0; wb_n = 0; ack_n = 0; ack_at = 0; dcu_n = 0; dcu_at = 0; dcu_val = -1;
    icu_n = 0; icu_at = 0; icu_val = -1; addr_ok = 1; hitm_last = 0;
    @(negedge clk);
    snp_inval = inv[0]; dc_lkp_hit = dch[0]; dc_lkp_state = 2'(dcs);
    ic_lkp_hit = ich[0]; ic_lkp_valid = icv[0]; snp_addr = a; snp_req = 1;
    for (int c = 1; c <= d + 10; c++) begin
      @(negedge clk);
      snp_req = (c == 2) ? 1'b1 : 1'b0;   // stray request mid-snoop
      snp_addr = ~a;
      if (c == 1 && tag_addr != a) addr_ok = 0;
      if (hitm) begin hitm_n++; hitm_last = c; end
      if (wb_req) begin
        wb_n++;
        if (wb_addr != a) addr_ok = 0;
      end
      if (snp_ack) begin ack_n++; if (ack_at == 0) ack_at = c; end
      if (dc_upd_en) begin dcu_n++; dcu_at = c; dcu_val = int'(dc_upd_state); end
      if (ic_upd_en) begin icu_n++; icu_at = c; icu_val = int'(ic_upd_valid); end
      wb_done = wb_req && (wb_n == d);
    end
    wb_done = 0;
    vdc = (dch != 0 && dcs != 0) ? 1 : 0;
    vic = (ich != 0 && icv != 0) ? 1 : 0;
    hit = vdc | vic;
    m = (dch != 0 && dcs == 3) ? 1 : 0;
    exp_ack = (hit == 0) ? 2 : (m != 0 ? 3 + d : 3);
    exp_dcu = (vdc != 0 && (inv != 0 || dcs != 1)) ? 1 : 0;
    exp_icu = (vic != 0 && inv != 0) ? 1 : 0;
    check(hit == 0 ? "R8 miss ack cycle" : "R7 ack cycle", ack_at, exp_ack);
    check("R12 one ack per snoop", ack_n, 1);
    check("R4 hitm cycles", hitm_n, m != 0 ? d + 1 : 0);
    if (m != 0) check("R4 hitm through wb_done", hitm_last, d + 1);
    check("R9 wb_req cycles", wb_n, m != 0 ? d : 0);
    check("R9 addresses", addr_ok, 1);
    check(inv != 0 ? "R6 dc update present" : "R3 dc update present", dcu_n, exp_dcu);
    if (exp_dcu != 0) begin
      // R10: S=01, I=00
      check(inv != 0 ? "R6 R10 dc state invalid" : "R3 R10 dc state shared",
            dcu_val, inv != 0 ? 0 : 1);
      check(m != 0 ? "R5 update after writeback" : "R7 update before ack", dcu_at, exp_ack - 1);
    end
    check(inv != 0 ? "R2 ic update present" : "R1 ic keeps state", icu_n, exp_icu);
    if (exp_icu != 0) begin
      check("R2 ic written invalid", icu_val, 0);
      check("R2 ic update cycle", icu_at, exp_ack - 1);
    end
  endtask

  initial begin
    int seq;
    seq = 0;
    repeat (3) @(negedge clk);
    check("R11 snp_ack reset", int'(snp_ack), 0);
    check("R11 hitm reset", int'(hitm), 0);
    check("R11 wb_req reset", int'(wb_req), 0);
    check("R11 upd reset", int'(dc_upd_en | ic_upd_en), 0);
    rst_n = 1;
    for (int inv = 0; inv < 2; inv++)
      for (int dch = 0; dch < 2; dch++)
        for (int dcs = 0; dcs < 4; dcs++)
          for (int ich = 0; ich < 2; ich++)
            for (int icv = 0; icv < 2; icv++) begin
              run_case(inv, dch, dcs, ich, icv, 1 + (seq % 4), seq);
              seq++;
            end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule